// File: doc/BRIEF.md
# SPI Master with Direction-Selectable Byte FIFO

This block is a serial peripheral interface master that a processor drives through a small byte-wide register window. Software chooses one FIFO direction per transfer. In output direction the processor fills the FIFO and the engine shifts each byte out on MOSI. In input direction the engine shifts bytes in from MISO and the processor drains them from the FIFO. A length register sets how many bytes the transfer moves. Writing a nonzero length starts the engine, and the engine runs until the length reaches zero. It pauses with the clock parked whenever the FIFO cannot supply or accept a byte.

The serial clock comes from a programmable divider. The idle clock level (mode 0 or mode 3) and the bit order are both selectable. Four sticky event flags are cleared by writing one, and each has its own enable into a single interrupt line. An all-clear command returns the data path to empty in one write.

Register offsets (3-bit address): 0 control, 1 interrupt enable, 2 divisor, 3 data port, 4 flags, 5 FIFO level, 6 length low, 7 length high.

Top module: `spi_fifo_master`

## Requirements
- R1: After reset, the flags register reads 0x40 (only the idle bit, bit 6, set), the FIFO level and the remaining length read 0, SCK is low, MOSI is high and the interrupt output is low.
- R2: The FIFO holds 8 bytes, and offset 5 reads the number of occupied entries.
- R3: Flag bit 3 is set in two cases: a data-port write in output direction while the FIFO is full, and a data-port read in input direction while it is empty. The offending access is dropped, the level does not change, and the read returns 0.
- R4: Control bit 1 chooses the idle SCK level (0 low, 1 high). During a bit, SCK is low for the first half and high for the second half. MISO is sampled at the rising edge, and MOSI changes only at bit boundaries.
- R5: Control bit 2 chooses the bit order: 0 sends and assembles bytes most significant bit first, 1 least significant bit first.
- R6: The SCK period equals the divisor (offset 2) in system clocks. Any divisor below 2 acts as 2.
- R7: A write to offset 6 stages the low byte. A write to offset 7 loads the remaining length from that write and the staged byte, and a nonzero value starts the transfer. The length drops by one per completed byte and reads back at offsets 6 and 7.
- R8: Control bit 0 chooses the direction. With 0 (output), FIFO bytes go out on MOSI and the engine waits while the FIFO is empty. With 1 (input), received bytes enter the FIFO, are read at offset 3, MOSI stays high, and the engine waits while the FIFO is full.
- R9: At offset 4, bit 1 sets on every completed byte and bit 0 sets when the length reaches zero. Bit 2 sets when the level rises to half the depth (4). Writing 1 to a bit clears it, and bit 6 reads 1 only while the engine is idle with no length left.
- R10: With control bit 3 set, any access to the data port clears flag bit 1. With control bit 3 clear, such accesses leave it set.
- R11: The interrupt output is high exactly when some flag in bits 0 to 3 is set together with the matching enable bit at offset 1.
- R12: Writing control with bit 7 set empties the FIFO, zeroes the length, aborts any byte in flight and clears all flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops the data port in input direction) |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: an 8-entry FIFO and a 16-bit length. The FIFO is therefore small enough that a length of 10 in input direction fills it and stalls the engine. An 8-byte output burst reaches both the half-full level and the overflow point. At run time the bench sweeps divisors from 0 to 6 to cover the clamp to 2 and odd periods. It also sweeps both clock polarities and both bit orders against a bench-side serial slave model.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;

  typedef enum logic [2:0] {
    A_CTRL   = 3'd0,
    A_IE     = 3'd1,
    A_DIV    = 3'd2,
    A_DATA   = 3'd3,
    A_FLAG   = 3'd4,
    A_LEVEL  = 3'd5,
    A_LEN_LO = 3'd6,
    A_LEN_HI = 3'd7
  } reg_addr_e;

  localparam int FL_CNT_END  = 0;
  localparam int FL_BYTE_END = 1;
  localparam int FL_HALF     = 2;
  localparam int FL_OVF      = 3;

  // divisor below 2 behaves as 2
  function automatic logic [7:0] eff_div(input logic [7:0] d);
    return (d < 8'd2) ? 8'd2 : d;
  endfunction

  // bit currently presented on the serial output
  function automatic logic head_bit(input logic [7:0] sh, input logic lsb);
    return lsb ? sh[0] : sh[7];
  endfunction

  // advance transmit shifter by one bit
  function automatic logic [7:0] shift_out(input logic [7:0] sh, input logic lsb);
    return lsb ? {1'b0, sh[7:1]} : {sh[6:0], 1'b0};
  endfunction

  // insert a received bit into the assembling byte
  function automatic logic [7:0] shift_in(input logic [7:0] sh, input logic b, input logic lsb);
    return lsb ? {b, sh[7:1]} : {sh[6:0], b};
  endfunction

endpackage

// File: rtl/spi_byte_fifo.sv
module spi_byte_fifo #(
  parameter int DEPTH = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         clr,
  input  logic                         push,
  input  logic [7:0]                   wdata,
  input  logic                         pop,
  output logic [7:0]                   rdata,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         full,
  output logic                         empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [7:0]    mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);
  assign rdata = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= nxt(wr_ptr);
      if (pop)  rd_ptr <= nxt(rd_ptr);
      if (push && !pop)      count <= count + 1'b1;
      else if (pop && !push) count <= count - 1'b1;
    end
  end
endmodule

// File: rtl/spi_bit_engine.sv
module spi_bit_engine
  import spi_fifo_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       cpol,
  input  logic       lsb_first,
  input  logic [7:0] div,
  input  logic       can_start,
  input  logic [7:0] tx_byte,
  input  logic       miso,
  output logic       sck,
  output logic       mosi,
  output logic       busy,
  output logic       start,
  output logic       done,
  output logic [7:0] rx_byte
);
  logic       active;
  logic [7:0] cnt, tx_sh, rx_sh;
  logic [2:0] bitn;
  logic       sck_q;

  logic [7:0] d_eff, half, cnt_inc;
  logic       mid_tick, last_tick;

  assign d_eff     = eff_div(div);
  assign half      = d_eff >> 1;
  assign cnt_inc   = cnt + 8'd1;
  assign mid_tick  = (cnt == half - 8'd1);
  assign last_tick = (cnt == d_eff - 8'd1);

  assign start   = can_start && !active;
  assign done    = active && last_tick && (bitn == 3'd7);
  assign busy    = active;
  assign sck     = sck_q;
  assign mosi    = active ? head_bit(tx_sh, lsb_first) : 1'b1;
  assign rx_byte = rx_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
      bitn   <= '0;
      tx_sh  <= '0;
      rx_sh  <= '0;
      sck_q  <= 1'b0;
    end else if (clr) begin
      active <= 1'b0;
      cnt    <= '0;
      sck_q  <= cpol;
    end else if (start) begin
      active <= 1'b1;
      cnt    <= '0;
      bitn   <= '0;
      tx_sh  <= tx_byte;
      sck_q  <= 1'b0;
    end else if (active) begin
      if (mid_tick) rx_sh <= shift_in(rx_sh, miso, lsb_first);
      if (last_tick) begin
        cnt <= '0;
        if (bitn == 3'd7) begin
          active <= 1'b0;
          sck_q  <= cpol;
        end else begin
          bitn  <= bitn + 3'd1;
          tx_sh <= shift_out(tx_sh, lsb_first);
          sck_q <= 1'b0;
        end
      end else begin
        cnt   <= cnt_inc;
        sck_q <= (cnt_inc >= half);
      end
    end else begin
      sck_q <= cpol;
    end
  end
endmodule

// File: rtl/spi_fifo_master.sv
module spi_fifo_master
  import spi_fifo_pkg::*;
#(
  parameter int FIFO_DEPTH = 8,
  parameter int LEN_W      = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [2:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       sck,
  output logic       mosi,
  input  logic       miso,
  output logic       irq
);
  localparam int CW   = $clog2(FIFO_DEPTH + 1);
  localparam int HALF = FIFO_DEPTH / 2;

  logic             dir_in, cpol, lsb_first, auto_clr;
  logic [3:0]       ie, flags, flag_set, flag_clr;
  logic [7:0]       div_q, len_stage;
  logic [LEN_W-1:0] remaining;
  logic [15:0]      rem16;
  logic             half_prev;

  // named events
  logic all_clr, data_wr, data_rd, len_load;
  logic bus_push, bus_pop, bad_access;
  logic eng_busy, eng_start, byte_done, can_start;
  logic fifo_push, fifo_pop, fifo_full, fifo_empty, half_lvl, free;
  logic [7:0] fifo_rdata, fifo_wdata, rx_byte;
  logic [CW-1:0] fifo_count;
  reg_addr_e a;

  assign a        = reg_addr_e'(bus_addr);
  assign all_clr  = bus_wr && (a == A_CTRL) && bus_wdata[7];
  assign data_wr  = bus_wr && (a == A_DATA);
  assign data_rd  = bus_rd && (a == A_DATA);
  assign len_load = bus_wr && (a == A_LEN_HI);

  assign bus_push   = data_wr && !dir_in && !fifo_full;
  assign bus_pop    = data_rd && dir_in && !fifo_empty;
  assign bad_access = (data_wr && !dir_in && fifo_full) || (data_rd && dir_in && fifo_empty);

  assign fifo_push  = bus_push || (byte_done && dir_in);
  assign fifo_pop   = bus_pop || (eng_start && !dir_in);
  assign fifo_wdata = dir_in ? rx_byte : bus_wdata;

  assign can_start = (remaining != '0) && !all_clr && (dir_in ? !fifo_full : !fifo_empty);
  assign half_lvl  = (fifo_count >= CW'(HALF));
  assign free      = !eng_busy && (remaining == '0);
  assign rem16     = 16'(remaining);

  spi_byte_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .clr(all_clr),
    .push(fifo_push), .wdata(fifo_wdata), .pop(fifo_pop),
    .rdata(fifo_rdata), .count(fifo_count), .full(fifo_full), .empty(fifo_empty)
  );

  spi_bit_engine u_eng (
    .clk(clk), .rst_n(rst_n), .clr(all_clr), .cpol(cpol), .lsb_first(lsb_first),
    .div(div_q), .can_start(can_start), .tx_byte(dir_in ? 8'hFF : fifo_rdata),
    .miso(miso), .sck(sck), .mosi(mosi), .busy(eng_busy), .start(eng_start),
    .done(byte_done), .rx_byte(rx_byte)
  );

  always_comb begin
    flag_set = '0;
    flag_set[FL_CNT_END]  = byte_done && (remaining == LEN_W'(1)) && !len_load;
    flag_set[FL_BYTE_END] = byte_done;
    flag_set[FL_HALF]     = half_lvl && !half_prev;
    flag_set[FL_OVF]      = bad_access;
    flag_clr = (bus_wr && (a == A_FLAG)) ? bus_wdata[3:0] : 4'b0;
    if (auto_clr && (data_wr || data_rd)) flag_clr[FL_BYTE_END] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_in    <= 1'b0;
      cpol      <= 1'b0;
      lsb_first <= 1'b0;
      auto_clr  <= 1'b0;
      ie        <= '0;
      div_q     <= 8'd2;
      len_stage <= '0;
      remaining <= '0;
      flags     <= '0;
      half_prev <= 1'b0;
    end else begin
      half_prev <= half_lvl;
      if (bus_wr) begin
        case (a)
          A_CTRL: {auto_clr, lsb_first, cpol, dir_in} <= bus_wdata[3:0];
          A_IE:     ie        <= bus_wdata[3:0];
          A_DIV:    div_q     <= bus_wdata;
          A_LEN_LO: len_stage <= bus_wdata;
          default: ;
        endcase
      end
      if (all_clr) begin
        remaining <= '0;
        flags     <= '0;
      end else begin
        if (len_load)       remaining <= LEN_W'({bus_wdata, len_stage});
        else if (byte_done) remaining <= remaining - 1'b1;
        flags <= (flags & ~flag_clr) | flag_set;
      end
    end
  end

  always_comb begin
    case (a)
      A_CTRL:   bus_rdata = {4'b0, auto_clr, lsb_first, cpol, dir_in};
      A_IE:     bus_rdata = {4'b0, ie};
      A_DIV:    bus_rdata = div_q;
      A_DATA:   bus_rdata = fifo_empty ? 8'h00 : fifo_rdata;
      A_FLAG:   bus_rdata = {1'b0, free, 2'b0, flags};
      A_LEVEL:  bus_rdata = 8'(fifo_count);
      A_LEN_LO: bus_rdata = rem16[7:0];
      default:  bus_rdata = rem16[15:8];
    endcase
  end

  assign irq = |(flags & ie);
endmodule

// File: rtl/spi_fifo_master_chk.sv
module spi_fifo_master_chk #(
  parameter int DEPTH = 8,
  parameter int CW    = 4,
  parameter int LEN_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sck,
  input logic             cpol,
  input logic             dir_in,
  input logic             eng_busy,
  input logic             eng_start,
  input logic             byte_done,
  input logic             all_clr,
  input logic             len_load,
  input logic             fifo_full,
  input logic             fifo_empty,
  input logic [CW-1:0]    fifo_count,
  input logic [LEN_W-1:0] remaining,
  input logic [3:0]       flags
);
  a_r2_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    int'(fifo_count) <= DEPTH);

  a_r2_level_step: assert property (@(posedge clk) disable iff (!rst_n)
    !all_clr |=> (int'(fifo_count) <= int'($past(fifo_count)) + 1) &&
                 (int'(fifo_count) + 1 >= int'($past(fifo_count))));

  a_r4_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    (!eng_busy && !$past(eng_busy) && (cpol == $past(cpol))) |-> (sck == cpol));

  a_r8_out_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_start && !dir_in) |-> !fifo_empty);

  a_r8_in_needs_room: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_start && dir_in) |-> !fifo_full);

  a_r7_no_start_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> (remaining != '0));

  a_r7_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && !len_load && !all_clr) |=> (remaining == $past(remaining) - 1'b1));

  a_r9_cnt_end: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && (remaining == LEN_W'(1)) && !len_load && !all_clr) |=> flags[0]);
endmodule

bind spi_fifo_master spi_fifo_master_chk #(
  .DEPTH(FIFO_DEPTH), .CW(CW), .LEN_W(LEN_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sck(sck), .cpol(cpol), .dir_in(dir_in),
  .eng_busy(eng_busy), .eng_start(eng_start), .byte_done(byte_done),
  .all_clr(all_clr), .len_load(len_load), .fifo_full(fifo_full),
  .fifo_empty(fifo_empty), .fifo_count(fifo_count), .remaining(remaining),
  .flags(flags)
);

// File: tb/spi_fifo_master_tb.sv
module spi_fifo_master_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic sck, mosi, miso = 1'b0, irq;

  int n_chk = 0, n_fail = 0;

  spi_fifo_master u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sck(sck), .mosi(mosi), .miso(miso), .irq(irq)
  );

  always #10 clk = ~clk;

  // ---- serial slave model ----
  logic [7:0] s_tx [16];
  logic [7:0] s_rx [16];
  logic [7:0] s_cur;
  int s_bi, s_byte, s_rx_n;
  logic s_en = 1'b0, s_lsb = 1'b0;
  realtime t_prev, t_last;

  function automatic logic pick(input logic [7:0] b, input int i, input logic lsb);
    return lsb ? b[i] : b[7-i];
  endfunction

  function automatic int exp_period(input logic [7:0] d);
    return (d < 2) ? 2 : int'(d);
  endfunction

  always @(posedge sck) begin
    t_prev = t_last;
    t_last = $realtime;
    if (s_en) begin
      s_cur = s_lsb ? {mosi, s_cur[7:1]} : {s_cur[6:0], mosi};
      s_bi++;
      if (s_bi == 8) begin
        if (s_rx_n < 16) s_rx[s_rx_n] = s_cur;
        s_rx_n++;
        s_bi = 0;
        s_byte++;
      end
      miso <= pick(s_tx[s_byte % 16], s_bi, s_lsb);
    end
  end

  task automatic slave_arm(input logic lsb);
    s_lsb = lsb; s_bi = 0; s_byte = 0; s_rx_n = 0; s_en = 1'b1;
    miso = pick(s_tx[0], 0, lsb);
  endtask

  // ---- bus tasks ----
  task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a; #2 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_free();
    logic [7:0] f;
    for (int i = 0; i < 8000; i++) begin
      bus_read(3'd4, f);
      if (f[6]) break;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] r, sent [8];
    void'($urandom(32'd1234));
    t_prev = 0; t_last = 0;
    for (int i = 0; i < 16; i++) s_tx[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    #2;
    chk("R1 sck", sck, 1'b0);
    chk("R1 mosi", mosi, 1'b1);
    chk("R1 irq", irq, 1'b0);
    bus_read(3'd4, r); chk("R1 flags", r, 8'h40);
    bus_read(3'd5, r); chk("R1 level", r, 8'h00);
    bus_read(3'd6, r); chk("R1 remaining", r, 8'h00);

    // random trials: R4 R5 R6 R7 R8 R9
    for (int t = 0; t < 10; t++) begin
      logic dirv, cp, lsb;
      logic [7:0] dv;
      int n;
      dirv = t[0];
      cp   = 1'($urandom_range(0, 1));
      lsb  = 1'($urandom_range(0, 1));
      dv   = 8'($urandom_range(0, 6));
      n    = $urandom_range(1, 8);
      if (t == 0) dv = 8'd0;
      if (t == 1) dv = 8'd1;
      s_en = 1'b0;
      bus_write(3'd0, {4'h8, 1'b0, lsb, cp, dirv});
      bus_write(3'd2, dv);
      idle(3);
      chk("R4 idle level", sck, cp);
      for (int i = 0; i < 16; i++) s_tx[i] = 8'($urandom());
      slave_arm(lsb);
      if (!dirv) begin
        for (int i = 0; i < n; i++) begin
          sent[i] = 8'($urandom());
          bus_write(3'd3, sent[i]);
        end
      end
      bus_write(3'd6, 8'(n));
      bus_write(3'd7, 8'h00);
      wait_free();
      chk("R4 idle after transfer", sck, cp);
      chk("R6 sck period", int'((t_last - t_prev) / 20.0), exp_period(dv));
      bus_read(3'd4, r);
      chk("R9 count end and byte end", r & 8'h03, 8'h03);
      if (!dirv) begin
        chk("R8 bytes sent", s_rx_n, n);
        for (int i = 0; i < n; i++) chk("R5 R8 mosi byte", s_rx[i], sent[i]);
      end else begin
        bus_read(3'd5, r); chk("R8 level after input", r, 8'(n));
        for (int i = 0; i < n; i++) begin
          bus_read(3'd3, r); chk("R5 R8 miso byte", r, s_tx[i]);
        end
      end
    end

    // R8 output stall on empty FIFO
    s_en = 1'b0;
    bus_write(3'd0, 8'h80);
    bus_write(3'd2, 8'd2);
    idle(2);
    slave_arm(1'b0);
    bus_write(3'd3, 8'hA5);
    bus_write(3'd6, 8'd3);
    bus_write(3'd7, 8'd0);
    idle(200);
    chk("R8 one byte before stall", s_rx_n, 1);
    bus_read(3'd6, r); chk("R7 remaining while stalled", r, 8'd2);
    bus_read(3'd4, r); chk("R9 not free while stalled", r[6], 1'b0);
    chk("R8 sck parked", sck, 1'b0);
    bus_write(3'd3, 8'h3C);
    bus_write(3'd3, 8'hC3);
    wait_free();
    chk("R8 resumed count", s_rx_n, 3);
    chk("R8 resumed byte", s_rx[2], 8'hC3);

    // R8 input stall on full FIFO, R2 depth
    s_en = 1'b0;
    bus_write(3'd0, 8'h81);
    idle(2);
    for (int i = 0; i < 16; i++) s_tx[i] = 8'(8'h10 + i);
    slave_arm(1'b0);
    bus_write(3'd6, 8'd10);
    bus_write(3'd7, 8'd0);
    idle(400);
    bus_read(3'd5, r); chk("R2 level full", r, 8'd8);
    bus_read(3'd6, r); chk("R8 remaining at full", r, 8'd2);
    bus_read(3'd4, r); chk("R9 half flag set", r[2], 1'b1);
    for (int i = 0; i < 8; i++) begin
      bus_read(3'd3, r); chk("R8 drain", r, 8'(8'h10 + i));
    end
    wait_free();
    bus_read(3'd5, r); chk("R8 last two in", r, 8'd2);
    bus_read(3'd3, r); chk("R8 byte 8", r, 8'h18);
    bus_read(3'd3, r); chk("R8 byte 9", r, 8'h19);

    // R3 underflow, R12 clear flags
    bus_read(3'd3, r); chk("R3 empty read returns 0", r, 8'h00);
    bus_read(3'd4, r); chk("R3 underflow flag", r[3], 1'b1);
    bus_read(3'd5, r); chk("R3 level unchanged", r, 8'd0);

    // R9 half boundary, R3 overflow, W1C
    s_en = 1'b0;
    bus_write(3'd0, 8'h80);
    bus_read(3'd4, r); chk("R12 flags cleared", r, 8'h40);
    for (int i = 0; i < 3; i++) bus_write(3'd3, 8'(i));
    bus_read(3'd4, r); chk("R9 half not at 3", r[2], 1'b0);
    bus_write(3'd3, 8'd3);
    bus_read(3'd4, r); chk("R9 half at 4", r[2], 1'b1);
    for (int i = 4; i < 9; i++) bus_write(3'd3, 8'(i));
    bus_read(3'd5, r); chk("R3 level capped", r, 8'd8);
    bus_read(3'd4, r); chk("R3 overflow flag", r[3], 1'b1);
    bus_write(3'd4, 8'h08);
    bus_read(3'd4, r); chk("R9 write one clears", r & 8'h0C, 8'h04);

    // R12 abort mid-transfer
    bus_write(3'd6, 8'h2C);
    bus_write(3'd7, 8'h01);
    idle(5);
    bus_read(3'd7, r); chk("R7 remaining high", r, 8'h01);
    bus_write(3'd0, 8'h80);
    idle(2);
    bus_read(3'd5, r); chk("R12 level zero", r, 8'd0);
    bus_read(3'd6, r); chk("R12 remaining zero", r, 8'd0);
    bus_read(3'd4, r); chk("R12 flags idle", r, 8'h40);
    chk("R12 sck idle", sck, 1'b0);

    // R10 auto clear and R11 irq
    bus_write(3'd3, 8'h55);
    bus_write(3'd6, 8'd1);
    bus_write(3'd7, 8'd0);
    wait_free();
    chk("R11 irq masked", irq, 1'b0);
    bus_write(3'd1, 8'h02);
    idle(1);
    chk("R11 irq on byte end", irq, 1'b1);
    bus_read(3'd3, r);
    bus_read(3'd4, r); chk("R10 no auto clear", r[1], 1'b1);
    bus_write(3'd0, 8'h08);
    bus_read(3'd3, r);
    bus_read(3'd4, r); chk("R10 auto clear", r[1], 1'b0);
    chk("R11 irq dropped", irq, 1'b0);

    summary();
    $finish;
  end
endmodule